// File: doc/BRIEF.md
# Packed Byte Left Shifter

This block executes a single packed-arithmetic operation. It treats a 32-bit operand as four separate 8-bit lanes. Every lane is shifted left by the same 3-bit amount taken from the instruction word, and the vacated low bits are filled with zeros. No bit moves from one lane into a neighbouring lane. The four shifted lanes are repacked in their original positions and returned one clock later, qualified by an output valid.

While it shifts, the block checks each lane for overflow, meaning that significant bits would be lost. If any lane overflows, the block sets a sticky flag at bit 22 of a 32-bit control/status register. Software can overwrite that register through a separate write port, and this is how the flag is cleared.

The block also checks the fixed fields of the incoming instruction word. An issued word that does not carry the expected encoding raises a decode-mismatch pulse and leaves both the result and the control register untouched. The destination and source register indices are carried forward with the result so that writeback can steer it.

Top module: `pbyte_shl`

## Requirements
- R1: Each 8-bit lane of `src_data` is shifted left by the shift amount independently, with zeros filling the vacated low bits and no bit entering an adjacent lane.
- R2: Lane k of the result is taken from bits [8k+7:8k] of `src_data` and placed in the same bit positions of `out_data`, with lane 3 in bits 31:24 and lane 0 in bits 7:0.
- R3: A shift amount of 0 returns `src_data` unchanged and never flags overflow, whatever the lane values are.
- R4: For a shift amount s from 1 to 7, a lane overflows when any of its original bits 7 down to 7−s is 1. Equivalently, the lane value is at least 2^(7−s).
- R5: When an accepted operation overflows in any lane, bit 22 of `csr_q` reads 1 from the next cycle onward. An operation never clears that bit.
- R6: When `csr_wr_en` is high, `csr_q` takes `csr_wr_data` at the next edge. If an overflow set happens in the same cycle, bit 22 is 1 and the other bits still come from `csr_wr_data`.
- R7: An operation is accepted only when `in_valid` is high and the encoding matches. `out_valid` is high for exactly the cycle after an accepted operation. `out_data`, `out_rt`, `out_rs` and the flag change only on an accepted operation.
- R8: The expected encoding has bits 31:26 = 001000, bit 12 = 0, bits 11:9 = 100, bits 8:6 = 001, bits 5:3 = 111 and bits 2:0 = 111. The shift amount is in bits 15:13, the destination index in bits 25:21 and the source index in bits 20:16. `out_rt` and `out_rs` return the indices of the last accepted operation.
- R9: When `in_valid` is high and the encoding does not match, `decode_err` is high in the next cycle, `out_valid` stays low, and `out_data` and `csr_q` keep their values.
- R10: After reset, `out_valid`, `decode_err`, `out_data`, `out_rt`, `out_rs` and `csr_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the instruction word and operand |
| insn | input | 32 | Instruction word |
| src_data | input | 32 | Packed source operand, four byte lanes |
| csr_wr_en | input | 1 | Software write enable for the control/status register |
| csr_wr_data | input | 32 | Value written to the control/status register |
| out_valid | output | 1 | Result valid, one cycle after an accepted operation |
| out_data | output | 32 | Packed shifted result |
| out_rt | output | 5 | Destination register index of the last accepted operation |
| out_rs | output | 5 | Source register index of the last accepted operation |
| decode_err | output | 1 | Encoding mismatch on an issued word, one cycle later |
| csr_q | output | 32 | Control/status register, sticky overflow at bit 22 |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, a 3-bit shift amount, a 32-bit control register and the flag at bit 22. With these values every shift amount from 0 to 7 can be reached, including the extremes where the overflow test covers a single lane bit (s=1 checks bits 7:6) or the whole lane (s=7). Lanes are loaded with values that sit exactly at and just below the overflow threshold. Other patterns fill one lane completely next to an empty one, to show that no bit crosses a lane boundary. A software write that lands in the same cycle as an overflow set, and words with a single wrong sub-field, are also within reach.

// File: rtl/pbyte_shl_pkg.sv
package pbyte_shl_pkg;

   localparam int unsigned INSN_W = 32;

   // Instruction word layout, most significant field first.
   typedef struct packed {
      logic [5:0] major;   // 31:26
      logic [4:0] rt;      // 25:21
      logic [4:0] rs;      // 20:16
      logic [2:0] sa;      // 15:13
      logic       zbit;    // 12
      logic [2:0] sub3;    // 11:9
      logic [2:0] sub2;    // 8:6
      logic [2:0] sub1;    // 5:3
      logic [2:0] sub0;    // 2:0
   } insn_t;

   localparam logic [5:0] MAJOR_VAL = 6'b001000;
   localparam logic       ZBIT_VAL  = 1'b0;
   localparam logic [2:0] SUB3_VAL  = 3'b100;
   localparam logic [2:0] SUB2_VAL  = 3'b001;
   localparam logic [2:0] SUB1_VAL  = 3'b111;
   localparam logic [2:0] SUB0_VAL  = 3'b111;

   localparam int unsigned SA_W  = 3;
   localparam int unsigned IDX_W = 5;

endpackage

// File: rtl/pbyte_insn_dec.sv
module pbyte_insn_dec
   import pbyte_shl_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output logic              enc_ok,
   output logic [SA_W-1:0]   sa,
   output logic [IDX_W-1:0]  rt,
   output logic [IDX_W-1:0]  rs
);

   insn_t fld;
   assign fld = insn_t'(insn);

   logic [5:0] fixed_hit;

   assign fixed_hit[0] = (fld.major == MAJOR_VAL);
   assign fixed_hit[1] = (fld.zbit  == ZBIT_VAL);
   assign fixed_hit[2] = (fld.sub3  == SUB3_VAL);
   assign fixed_hit[3] = (fld.sub2  == SUB2_VAL);
   assign fixed_hit[4] = (fld.sub1  == SUB1_VAL);
   assign fixed_hit[5] = (fld.sub0  == SUB0_VAL);

   assign enc_ok = &fixed_hit;
   assign sa     = fld.sa;
   assign rt     = fld.rt;
   assign rs     = fld.rs;

endmodule

// File: rtl/pbyte_lane_shl.sv
module pbyte_lane_shl #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned SH_W   = 3
) (
   input  logic [LANE_W-1:0] lane_in,
   input  logic [SH_W-1:0]   amt,
   output logic [LANE_W-1:0] lane_out,
   output logic              lane_ovf
);

   localparam logic [LANE_W-1:0] ONES = '1;

   logic [SH_W:0]     amt_p1;
   logic [LANE_W-1:0] lost_mask;

   // Zero fill comes from the shift operator; the width keeps the lane closed.
   assign lane_out = lane_in << amt;

   // The bits that must be clear for a lossless shift: top amt+1 bits of the lane.
   assign amt_p1    = {1'b0, amt} + 1'b1;
   assign lost_mask = ~(ONES >> amt_p1);
   assign lane_ovf  = (amt != '0) && ((lane_in & lost_mask) != '0);

endmodule

// File: rtl/pbyte_csr.sv
module pbyte_csr #(
   parameter int unsigned CSR_W   = 32,
   parameter int unsigned FLAG_AT = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CSR_W-1:0] wr_data,
   input  logic             flag_set,
   output logic [CSR_W-1:0] q
);

   for (genvar b = 0; b < CSR_W; b++) begin : g_bit
      if (b == FLAG_AT) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n)        q[b] <= 1'b0;
            else if (flag_set) q[b] <= 1'b1;
            else if (wr_en)    q[b] <= wr_data[b];
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)     q[b] <= 1'b0;
            else if (wr_en) q[b] <= wr_data[b];
         end
      end
   end

endmodule

// File: rtl/pbyte_shl.sv
module pbyte_shl
   import pbyte_shl_pkg::*;
#(
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned CSR_W   = 32,
   parameter int unsigned FLAG_AT = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       insn,
   input  logic [31:0]       src_data,
   input  logic              csr_wr_en,
   input  logic [31:0]       csr_wr_data,
   output logic              out_valid,
   output logic [31:0]       out_data,
   output logic [4:0]        out_rt,
   output logic [4:0]        out_rs,
   output logic              decode_err,
   output logic [31:0]       csr_q
);

   localparam int unsigned DATA_W = LANES * LANE_W;
   localparam int unsigned SH_W   = $clog2(LANE_W);

   initial begin
      if (DATA_W != 32) $error("pbyte_shl: LANES*LANE_W must be 32");
      if (SH_W != SA_W) $error("pbyte_shl: lane width must match the 3-bit shift field");
      if ((1 << SH_W) != LANE_W) $error("pbyte_shl: LANE_W must be a power of two");
      if (CSR_W != 32) $error("pbyte_shl: CSR_W must be 32");
      if (FLAG_AT >= CSR_W) $error("pbyte_shl: FLAG_AT outside the register");
      if (INSN_W != 32) $error("pbyte_shl: instruction word must be 32 bits");
   end

   logic              dec_ok;
   logic [SA_W-1:0]   dec_sa;
   logic [IDX_W-1:0]  dec_rt;
   logic [IDX_W-1:0]  dec_rs;
   logic              fire;
   logic [DATA_W-1:0] shifted;
   logic [LANES-1:0]  lane_ovf;
   logic              any_ovf;

   pbyte_insn_dec u_dec (
      .insn   (insn),
      .enc_ok (dec_ok),
      .sa     (dec_sa),
      .rt     (dec_rt),
      .rs     (dec_rs)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pbyte_lane_shl #(
         .LANE_W (LANE_W),
         .SH_W   (SH_W)
      ) u_lane (
         .lane_in  (src_data[k*LANE_W +: LANE_W]),
         .amt      (dec_sa),
         .lane_out (shifted[k*LANE_W +: LANE_W]),
         .lane_ovf (lane_ovf[k])
      );
   end

   assign any_ovf = |lane_ovf;
   assign fire    = in_valid & dec_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         decode_err <= 1'b0;
         out_data   <= '0;
         out_rt     <= '0;
         out_rs     <= '0;
      end else begin
         out_valid  <= fire;
         decode_err <= in_valid & ~dec_ok;
         if (fire) begin
            out_data <= shifted;
            out_rt   <= dec_rt;
            out_rs   <= dec_rs;
         end
      end
   end

   pbyte_csr #(
      .CSR_W   (CSR_W),
      .FLAG_AT (FLAG_AT)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (csr_wr_en),
      .wr_data  (csr_wr_data),
      .flag_set (fire & any_ovf),
      .q        (csr_q)
   );

endmodule

// File: rtl/pbyte_shl_chk.sv
module pbyte_shl_chk #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned FLAG_AT = 22
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] src_data,
   input logic [2:0]  sa,
   input logic        dec_ok,
   input logic        any_ovf,
   input logic        csr_wr_en,
   input logic        out_valid,
   input logic [31:0] out_data,
   input logic        decode_err,
   input logic [31:0] csr_q
);

   // R3: zero shift returns the operand
   p_zero_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_ok && sa == 3'd0) |=> (out_valid && out_data == $past(src_data)));

   // R3: zero shift raises no lane overflow
   p_zero_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sa == 3'd0) |-> !any_ovf);

   // R1: lowest bit of every lane is zero after a nonzero shift
   for (genvar k = 0; k < LANES; k++) begin : g_fill
      p_zero_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dec_ok && sa != 3'd0) |=> (out_data[k*LANE_W] == 1'b0));
   end

   // R5: an accepted overflow sets the flag
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_ok && any_ovf) |=> csr_q[FLAG_AT]);

   // R5: without a software write the flag never falls
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_q[FLAG_AT] && !csr_wr_en) |=> csr_q[FLAG_AT]);

   // R7: idle input gives no output strobes
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !decode_err));

   // R7: data holds when nothing is accepted
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && dec_ok) |=> $stable(out_data));

   // R9: mismatch reports and leaves register state alone
   p_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_ok && !csr_wr_en) |=> (decode_err && !out_valid && $stable(csr_q)));

   // R9: the two output strobes exclude each other
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && decode_err));

endmodule

bind pbyte_shl pbyte_shl_chk #(
   .LANES   (LANES),
   .LANE_W  (LANE_W),
   .FLAG_AT (FLAG_AT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .src_data   (src_data),
   .sa         (dec_sa),
   .dec_ok     (dec_ok),
   .any_ovf    (any_ovf),
   .csr_wr_en  (csr_wr_en),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .decode_err (decode_err),
   .csr_q      (csr_q)
);

// File: tb/pbyte_shl_tb.sv
module pbyte_shl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;
   localparam int FLAG = 22;

   // Stimulus table: operand, shift amount, expected result, expected overflow.
   localparam logic [31:0] V_SRC [NVEC] = '{
      32'h01020304, 32'h80FF7F01, 32'h01010101, 32'h0F0F0F0F, 32'h07070707,
      32'h3F000000, 32'h00000040, 32'h12345678, 32'h00800000, 32'h000F0000,
      32'h00000001, 32'h00000002, 32'h00FF00FF };
   localparam logic [2:0]  V_SA  [NVEC] = '{
      3'd1, 3'd0, 3'd7, 3'd4, 3'd4, 3'd1, 3'd1, 3'd3, 3'd0, 3'd2, 3'd6, 3'd6, 3'd1 };
   localparam logic [31:0] V_EXP [NVEC] = '{
      32'h02040608, 32'h80FF7F01, 32'h80808080, 32'hF0F0F0F0, 32'h70707070,
      32'h7E000000, 32'h00000080, 32'h90A0B0C0, 32'h00800000, 32'h003C0000,
      32'h00000040, 32'h00000080, 32'h00FE00FE };
   localparam logic        V_OVF [NVEC] = '{
      1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] src_data = '0;
   logic        csr_wr_en = 1'b0;
   logic [31:0] csr_wr_data = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic [4:0]  out_rt;
   logic [4:0]  out_rs;
   logic        decode_err;
   logic [31:0] csr_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbyte_shl dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .src_data(src_data), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
      .out_valid(out_valid), .out_data(out_data), .out_rt(out_rt), .out_rs(out_rs),
      .decode_err(decode_err), .csr_q(csr_q));

   function automatic logic [31:0] mk_insn(input logic [4:0] rt, input logic [4:0] rs,
                                            input logic [2:0] sa);
      return {6'b001000, rt, rs, sa, 1'b0, 3'b100, 3'b001, 3'b111, 3'b111};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive one cycle of inputs just after an edge; sample just after the next edge.
   task automatic cycle(input logic v, input logic [31:0] w, input logic [31:0] d,
                        input logic we, input logic [31:0] wd);
      in_valid = v; insn = w; src_data = d; csr_wr_en = we; csr_wr_data = wd;
      @(posedge clk); #1;
      in_valid = 1'b0; csr_wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check("R10", "out_valid", {31'd0, out_valid}, 32'd0);
      check("R10", "decode_err", {31'd0, decode_err}, 32'd0);
      check("R10", "out_data", out_data, 32'd0);
      check("R10", "out_rt/rs", {22'd0, out_rt, out_rs}, 32'd0);
      check("R10", "csr_q", csr_q, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 R2 R3 R4 R5: table walk, flag cleared before each vector
      for (int i = 0; i < NVEC; i++) begin
         cycle(1'b0, '0, '0, 1'b1, 32'd0);
         cycle(1'b1, mk_insn(5'(i), 5'(i + 7), V_SA[i]), V_SRC[i], 1'b0, '0);
         check(V_SA[i] == 3'd0 ? "R3" : "R1", "out_data", out_data, V_EXP[i]);
         check("R7", "out_valid", {31'd0, out_valid}, 32'd1);
         check("R4", "flag", {31'd0, csr_q[FLAG]}, {31'd0, V_OVF[i]});
         check("R8", "out_rt/rs", {22'd0, out_rt, out_rs}, {22'd0, 5'(i), 5'(i + 7)});
      end

      // R7: out_valid lasts one cycle
      cycle(1'b0, '0, '0, 1'b0, '0);
      check("R7", "out_valid drop", {31'd0, out_valid}, 32'd0);

      // R5: sticky flag survives a later non-overflowing operation
      cycle(1'b1, mk_insn(5'd1, 5'd2, 3'd7), 32'h000000FF, 1'b0, '0);
      cycle(1'b1, mk_insn(5'd1, 5'd2, 3'd1), 32'h01010101, 1'b0, '0);
      check("R5", "sticky flag", {31'd0, csr_q[FLAG]}, 32'd1);
      check("R2", "lane packing", out_data, 32'h02020202);

      // R6: software write replaces the register and clears the flag
      cycle(1'b0, '0, '0, 1'b1, 32'h0000_1234);
      check("R6", "csr write", csr_q, 32'h0000_1234);

      // R6: set wins over a same-cycle write, other bits from write data
      cycle(1'b1, mk_insn(5'd3, 5'd4, 3'd1), 32'h80000000, 1'b1, 32'h0000_00A5);
      check("R6", "set priority", csr_q, 32'h0040_00A5);
      check("R2", "top lane only", out_data, 32'h00000000);

      // R7: overflowing operand without in_valid changes nothing
      cycle(1'b0, '0, '0, 1'b1, 32'd0);
      held = out_data;
      cycle(1'b0, mk_insn(5'd9, 5'd9, 3'd7), 32'hFFFFFFFF, 1'b0, '0);
      check("R7", "idle out_valid", {31'd0, out_valid}, 32'd0);
      check("R7", "idle out_data", out_data, held);
      check("R7", "idle flag", csr_q, 32'd0);

      // R9 R8: wrong sub-field (bits 5:3 = 110) with an overflowing operand
      cycle(1'b1, mk_insn(5'd9, 5'd9, 3'd7) ^ 32'h0000_0008, 32'hFFFFFFFF, 1'b0, '0);
      check("R9", "decode_err", {31'd0, decode_err}, 32'd1);
      check("R9", "no out_valid", {31'd0, out_valid}, 32'd0);
      check("R9", "out_data held", out_data, held);
      check("R9", "csr held", csr_q, 32'd0);
      check("R8", "rt kept", {27'd0, out_rt}, 32'd3);

      // R8 R9: wrong major opcode and wrong bit 12
      cycle(1'b1, mk_insn(5'd9, 5'd9, 3'd7) ^ 32'h0400_0000, 32'hFFFFFFFF, 1'b0, '0);
      check("R8", "opcode mismatch", {31'd0, decode_err}, 32'd1);
      cycle(1'b1, mk_insn(5'd9, 5'd9, 3'd7) ^ 32'h0000_1000, 32'hFFFFFFFF, 1'b0, '0);
      check("R8", "bit12 mismatch", {31'd0, decode_err}, 32'd1);
      check("R9", "csr still held", csr_q, 32'd0);
      cycle(1'b0, '0, '0, 1'b0, '0);
      check("R9", "decode_err pulse", {31'd0, decode_err}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule